// File: doc/BRIEF.md
# Single-Byte Command Decoder for a Coding Test Rig

This block sits between a UART receiver and a UART transmitter. It holds the run-time settings of a channel-coding test system. Each received character is a complete command. The upper nibble names the action and the lower nibble carries its argument, so the host can retune the rig between runs without any framing or length fields.

The decoder keeps three settings in registers: the base-2 logarithm of the code length, the information-bit setting, and the erasure probability of the simulated erasure channel in steps of 1/16. These settings drive the encoder, channel and decoder datapaths, which lie outside this block. A start command raises a one-cycle pulse and marks a run as active until the datapath reports completion. A read command returns one byte of the datapath's error counter. Every processed command produces exactly one reply byte. The reply is held in a single slot toward the transmitter and released with a valid/ready handshake.

Top module: `bec_cmd_decoder`

## Requirements
- R1: Bits [7:4] of a received byte are the opcode and bits [3:0] the operand. Opcode 0x1 loads the operand into the code-length exponent only when it lies in MIN_LOG2..MAX_LOG2 and replies with the received byte. Outside that range the exponent is kept and the reply is 0xEE.
- R2: Opcode 0x2 loads the operand into the information-bit setting and echoes the byte.
- R3: Opcode 0x3 loads the operand into the erasure probability (sixteenths) and echoes the byte.
- R4: Opcode 0x4 with no run active echoes the byte and raises run_start for exactly one cycle. run_start and run_busy go high on the same clock edge that takes the byte. run_busy stays high until the edge that samples run_done.
- R5: Opcode 0x5 replies with byte number `operand` of err_count (byte 0 = bits 7:0). It replies 0xEE when the operand is not below CNT_W/8. It is served whether or not a run is active.
- R6: Opcode 0x0 changes nothing and echoes the byte, whatever the operand.
- R7: Opcodes 0x6 to 0xF change nothing and reply 0xEE.
- R8: While run_busy is high, opcodes 0x1 to 0x4 change nothing, start nothing and reply 0xEB. This holds even when the operand would otherwise be out of range.
- R9: A pending reply keeps tx_valid high and tx_data unchanged until tx_ready is seen. A byte that arrives while a reply is pending is dropped: it has no effect and gets no reply.
- R10: After reset the exponent is DEF_LOG2, the information setting is DEF_INFO, the erasure probability is DEF_ERASE, and run_busy, run_start and tx_valid are low.
- R11: run_done while no run is active is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_data | input | 8 | Received command byte |
| rx_valid | input | 1 | One-cycle strobe marking rx_data |
| tx_data | output | 8 | Reply byte |
| tx_valid | output | 1 | Reply pending |
| tx_ready | input | 1 | Transmitter takes the reply |
| err_count | input | CNT_W | Error counter from the datapath |
| run_done | input | 1 | Datapath finished the active run |
| run_start | output | 1 | One-cycle run start pulse |
| run_busy | output | 1 | A run is active |
| len_log2 | output | 4 | Code-length exponent |
| info_sel | output | 4 | Information-bit setting |
| erase_p16 | output | 4 | Erasure probability in sixteenths |

## Verification
The bench goes after the exponent bounds on both sides (2 and 11 rejected, 3 and 10 taken). A design with an off-by-one in the range check would echo and load a forbidden length. It sends configuration and start commands during an active run. A decoder that ignored the busy flag would move the settings or emit a second start pulse. It holds tx_ready low while another byte arrives. A slot that overwrote its content would lose the first reply or apply the dropped command. It also reads the error-count bytes on and past the last valid index. A wrong byte slice or a missing index check would show up as the wrong reply value.

// File: rtl/bec_cmd_pkg.sv
package bec_cmd_pkg;

  localparam logic [3:0] OP_NOP   = 4'h0;
  localparam logic [3:0] OP_LEN   = 4'h1;
  localparam logic [3:0] OP_INFO  = 4'h2;
  localparam logic [3:0] OP_ERASE = 4'h3;
  localparam logic [3:0] OP_START = 4'h4;
  localparam logic [3:0] OP_READ  = 4'h5;

  localparam logic [7:0] REPLY_BAD  = 8'hEE;
  localparam logic [7:0] REPLY_BUSY = 8'hEB;

  typedef struct packed {
    logic [3:0] opcode;
    logic [3:0] operand;
  } cmd_t;

endpackage

// File: rtl/bec_cmd_classify.sv
module bec_cmd_classify
  import bec_cmd_pkg::*;
#(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned MIN_LOG2 = 3,
  parameter int unsigned MAX_LOG2 = 10
) (
  input  logic             cmd_valid,
  input  logic [7:0]       cmd_byte,
  input  logic             busy,
  input  logic [CNT_W-1:0] err_count,
  output logic             wr_len,
  output logic             wr_info,
  output logic             wr_erase,
  output logic             start_req,
  output logic [7:0]       reply
);

  localparam int unsigned NBYTES = CNT_W / 8;
  localparam logic [3:0]  LO_N   = 4'(MIN_LOG2);
  localparam logic [3:0]  HI_N   = 4'(MAX_LOG2);

  cmd_t       cmd;
  logic [7:0] rd_byte;
  logic       rd_ok;
  logic       len_ok;

  assign cmd    = cmd_t'(cmd_byte);
  assign len_ok = (cmd.operand >= LO_N) && (cmd.operand <= HI_N);

  // Byte picker over the error counter, one lane per counter byte.
  always_comb begin
    rd_byte = 8'h00;
    rd_ok   = 1'b0;
    for (int i = 0; i < int'(NBYTES); i++) begin
      if (int'(cmd.operand) == i) begin
        rd_byte = err_count[i*8 +: 8];
        rd_ok   = 1'b1;
      end
    end
  end

  always_comb begin
    wr_len    = 1'b0;
    wr_info   = 1'b0;
    wr_erase  = 1'b0;
    start_req = 1'b0;
    reply     = cmd_byte;
    case (cmd.opcode)
      OP_NOP: reply = cmd_byte;
      OP_LEN: begin
        if (busy)        reply  = REPLY_BUSY;
        else if (len_ok) wr_len = cmd_valid;
        else             reply  = REPLY_BAD;
      end
      OP_INFO: begin
        if (busy) reply   = REPLY_BUSY;
        else      wr_info = cmd_valid;
      end
      OP_ERASE: begin
        if (busy) reply    = REPLY_BUSY;
        else      wr_erase = cmd_valid;
      end
      OP_START: begin
        if (busy) reply     = REPLY_BUSY;
        else      start_req = cmd_valid;
      end
      OP_READ: reply = rd_ok ? rd_byte : REPLY_BAD;
      default: reply = REPLY_BAD;
    endcase
  end

endmodule

// File: rtl/bec_param_regs.sv
module bec_param_regs #(
  parameter int unsigned DEF_LOG2  = 3,
  parameter int unsigned DEF_INFO  = 8,
  parameter int unsigned DEF_ERASE = 0,
  parameter int unsigned MIN_LOG2  = 3,
  parameter int unsigned MAX_LOG2  = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       busy,
  input  logic       wr_len,
  input  logic       wr_info,
  input  logic       wr_erase,
  input  logic [3:0] operand,
  output logic [3:0] len_log2,
  output logic [3:0] info_sel,
  output logic [3:0] erase_p16
);

  localparam logic [3:0] RST_LEN   = 4'(DEF_LOG2);
  localparam logic [3:0] RST_INFO  = 4'(DEF_INFO);
  localparam logic [3:0] RST_ERASE = 4'(DEF_ERASE);
  localparam logic [3:0] LO_N      = 4'(MIN_LOG2);
  localparam logic [3:0] HI_N      = 4'(MAX_LOG2);

  logic [3:0] len_d, info_d, erase_d;

  always_comb begin
    len_d   = len_log2;
    info_d  = info_sel;
    erase_d = erase_p16;
    if (wr_len)   len_d   = operand;
    if (wr_info)  info_d  = operand;
    if (wr_erase) erase_d = operand;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_log2  <= RST_LEN;
      info_sel  <= RST_INFO;
      erase_p16 <= RST_ERASE;
    end else begin
      len_log2  <= len_d;
      info_sel  <= info_d;
      erase_p16 <= erase_d;
    end
  end

  // R8
  busy_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(len_log2) && $stable(info_sel) && $stable(erase_p16)));

  // R1
  len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (len_log2 >= LO_N) && (len_log2 <= HI_N));

endmodule

// File: rtl/bec_run_ctrl.sv
module bec_run_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  input  logic run_done,
  output logic run_start,
  output logic run_busy
);

  logic busy_d;

  always_comb begin
    busy_d = run_busy;
    if (start_req)     busy_d = 1'b1;
    else if (run_done) busy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_busy  <= 1'b0;
      run_start <= 1'b0;
    end else begin
      run_busy  <= busy_d;
      run_start <= start_req;
    end
  end

  // R4
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_start |=> !run_start);

  // R4
  busy_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_busy) |-> run_start);

  // R11
  idle_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_busy && !start_req) |=> !run_busy);

endmodule

// File: rtl/bec_resp_slot.sv
module bec_resp_slot (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] load_data,
  input  logic       tx_ready,
  output logic       tx_valid,
  output logic [7:0] tx_data
);

  logic       valid_d;
  logic [7:0] data_d;
  logic       data_en;

  assign data_en = load;

  always_comb begin
    valid_d = tx_valid;
    data_d  = tx_data;
    if (load) begin
      valid_d = 1'b1;
      data_d  = load_data;
    end else if (tx_ready) begin
      valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_valid <= 1'b0;
    else        tx_valid <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tx_data <= 8'h00;
    else if (data_en) tx_data <= data_d;
  end

  // R9
  hold_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  // R9
  no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !tx_valid);

endmodule

// File: rtl/bec_cmd_decoder.sv
module bec_cmd_decoder
  import bec_cmd_pkg::*;
#(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned MIN_LOG2  = 3,
  parameter int unsigned MAX_LOG2  = 10,
  parameter int unsigned DEF_LOG2  = 3,
  parameter int unsigned DEF_INFO  = 8,
  parameter int unsigned DEF_ERASE = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       rx_data,
  input  logic             rx_valid,
  output logic [7:0]       tx_data,
  output logic             tx_valid,
  input  logic             tx_ready,
  input  logic [CNT_W-1:0] err_count,
  input  logic             run_done,
  output logic             run_start,
  output logic             run_busy,
  output logic [3:0]       len_log2,
  output logic [3:0]       info_sel,
  output logic [3:0]       erase_p16
);

  logic [1:0] rst_pipe;
  logic       rst_n_s;
  logic       accept;
  logic       wr_len, wr_info, wr_erase, start_req;
  logic [7:0] reply;

  // Reset asserts at once and leaves after two clean edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  // A command is taken only while the reply slot is empty.
  assign accept = rx_valid && !tx_valid;

  bec_cmd_classify #(
    .CNT_W    (CNT_W),
    .MIN_LOG2 (MIN_LOG2),
    .MAX_LOG2 (MAX_LOG2)
  ) u_classify (
    .cmd_valid (accept),
    .cmd_byte  (rx_data),
    .busy      (run_busy),
    .err_count (err_count),
    .wr_len    (wr_len),
    .wr_info   (wr_info),
    .wr_erase  (wr_erase),
    .start_req (start_req),
    .reply     (reply)
  );

  bec_param_regs #(
    .DEF_LOG2  (DEF_LOG2),
    .DEF_INFO  (DEF_INFO),
    .DEF_ERASE (DEF_ERASE),
    .MIN_LOG2  (MIN_LOG2),
    .MAX_LOG2  (MAX_LOG2)
  ) u_params (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .busy      (run_busy),
    .wr_len    (wr_len),
    .wr_info   (wr_info),
    .wr_erase  (wr_erase),
    .operand   (rx_data[3:0]),
    .len_log2  (len_log2),
    .info_sel  (info_sel),
    .erase_p16 (erase_p16)
  );

  bec_run_ctrl u_run (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .start_req (start_req),
    .run_done  (run_done),
    .run_start (run_start),
    .run_busy  (run_busy)
  );

  bec_resp_slot u_resp (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .load      (accept),
    .load_data (reply),
    .tx_ready  (tx_ready),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data)
  );

  // R7
  unknown_op_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (accept && (rx_data[7:4] > OP_READ)) |=> (tx_valid && tx_data == REPLY_BAD));

  // R6
  nop_echo_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (accept && rx_data[7:4] == OP_NOP) |=> (tx_data == $past(rx_data)));

endmodule

// File: tb/bec_cmd_decoder_tb.sv
`timescale 1ns/1ps
module bec_cmd_decoder_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  rx_data;
  logic        rx_valid;
  logic [7:0]  tx_data;
  logic        tx_valid;
  logic        tx_ready;
  logic [15:0] err_count;
  logic        run_done;
  logic        run_start;
  logic        run_busy;
  logic [3:0]  len_log2, info_sel, erase_p16;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  bec_cmd_decoder u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_data   (rx_data),
    .rx_valid  (rx_valid),
    .tx_data   (tx_data),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .err_count (err_count),
    .run_done  (run_done),
    .run_start (run_start),
    .run_busy  (run_busy),
    .len_log2  (len_log2),
    .info_sel  (info_sel),
    .erase_p16 (erase_p16)
  );

  // {cmd, reply, exponent, info, erasure}, starting from reset values 3/8/0
  localparam logic [27:0] VEC [16] = '{
    {8'h15, 8'h15, 4'h5, 4'h8, 4'h0},  // R1 legal exponent
    {8'h26, 8'h26, 4'h5, 4'h6, 4'h0},  // R2
    {8'h37, 8'h37, 4'h5, 4'h6, 4'h7},  // R3
    {8'h12, 8'hEE, 4'h5, 4'h6, 4'h7},  // R1 below minimum
    {8'h1B, 8'hEE, 4'h5, 4'h6, 4'h7},  // R1 above maximum
    {8'h1A, 8'h1A, 4'hA, 4'h6, 4'h7},  // R1 top edge
    {8'h13, 8'h13, 4'h3, 4'h6, 4'h7},  // R1 bottom edge
    {8'h00, 8'h00, 4'h3, 4'h6, 4'h7},  // R6
    {8'h0F, 8'h0F, 4'h3, 4'h6, 4'h7},  // R6 any operand
    {8'h69, 8'hEE, 4'h3, 4'h6, 4'h7},  // R7
    {8'hF0, 8'hEE, 4'h3, 4'h6, 4'h7},  // R7
    {8'h50, 8'hC3, 4'h3, 4'h6, 4'h7},  // R5 low byte
    {8'h51, 8'hA5, 4'h3, 4'h6, 4'h7},  // R5 high byte
    {8'h52, 8'hEE, 4'h3, 4'h6, 4'h7},  // R5 index past end
    {8'h3F, 8'h3F, 4'h3, 4'h6, 4'hF},  // R3 maximum
    {8'h20, 8'h20, 4'h3, 4'h0, 4'hF}   // R2 zero
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    rx_data  = b;
    rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic pop();
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
  endtask

  task automatic params(input string req, input logic [11:0] exp);
    chk(req, {4'h0, len_log2, info_sel, erase_p16}, {4'h0, exp});
  endtask

  initial begin
    rst_n     = 1'b0;
    rx_data   = 8'h00;
    rx_valid  = 1'b0;
    tx_ready  = 1'b0;
    run_done  = 1'b0;
    err_count = 16'hA5C3;
    repeat (3) @(negedge clk);
    // R10 reset values
    params("R10", 12'h380);
    chk("R10 busy/start/valid", {13'h0, run_busy, run_start, tx_valid}, 16'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < 16; i++) begin
      send(VEC[i][27:20]);
      chk("R1-R7 table valid", {15'h0, tx_valid}, 16'h1);
      chk("R1-R7 table reply", {8'h0, tx_data}, {8'h0, VEC[i][19:12]});
      params("R1-R7 table params", VEC[i][11:0]);
      pop();
      chk("R9 slot released", {15'h0, tx_valid}, 16'h0);
    end

    // R4 start a run
    send(8'h40);
    chk("R4 echo", {8'h0, tx_data}, 16'h0040);
    chk("R4 pulse/busy", {14'h0, run_start, run_busy}, 16'h3);
    pop();
    chk("R4 pulse width", {14'h0, run_start, run_busy}, 16'h1);
    // R8 writes while busy
    send(8'h17);
    chk("R8 busy reply", {8'h0, tx_data}, 16'h00EB);
    params("R8 frozen", 12'h30F);
    pop();
    send(8'h1B);
    chk("R8 busy before range", {8'h0, tx_data}, 16'h00EB);
    pop();
    send(8'h40);
    chk("R8 second start", {8'h0, tx_data}, 16'h00EB);
    chk("R8 no pulse", {15'h0, run_start}, 16'h0);
    pop();
    send(8'h51);
    chk("R5 read while busy", {8'h0, tx_data}, 16'h00A5);
    pop();
    send(8'h77);
    chk("R7 while busy", {8'h0, tx_data}, 16'h00EE);
    pop();
    @(negedge clk);
    run_done = 1'b1;
    @(negedge clk);
    run_done = 1'b0;
    chk("R4 busy cleared", {15'h0, run_busy}, 16'h0);
    send(8'h17);
    chk("R1 after run", {8'h0, tx_data}, 16'h0017);
    params("R1 after run", 12'h70F);
    pop();
    // R11 stray completion
    @(negedge clk);
    run_done = 1'b1;
    @(negedge clk);
    run_done = 1'b0;
    chk("R11 idle done", {14'h0, run_start, run_busy}, 16'h0);

    // R9 backpressure and drop
    send(8'h25);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R9 hold", {7'h0, tx_valid, tx_data}, 16'h0125);
    end
    send(8'h34);
    chk("R9 held after drop", {7'h0, tx_valid, tx_data}, 16'h0125);
    params("R9 dropped byte", 12'h75F);
    pop();
    @(negedge clk);
    chk("R9 no reply for dropped", {15'h0, tx_valid}, 16'h0);

    // R10 reset from a used state
    send(8'h40);
    rst_n = 1'b0;
    @(negedge clk);
    params("R10 mid reset", 12'h380);
    chk("R10 mid reset flags", {13'h0, run_busy, run_start, tx_valid}, 16'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule